// File: doc/BRIEF.md
# Wake Event PME Output Controller

This block turns wake-up detections from a network MAC (a wake-up frame or a magic packet) into a power-management-event pin. A small control/status register selects how the pin behaves. The buffer type is either open-drain, for a wired-OR line, or push-pull. The indication is either a fixed-length pulse or a level held until released. The polarity applies in push-pull mode only. An enable gates the pin. A sticky wake status bit is cleared by writing a one to it. The status bit is also presented as an interrupt-status flag, and the enable does not gate that flag.

The block does not drive a tristate buffer itself. It provides a drive value and an output-enable, so the pad logic can build either buffer type from them. In open-drain mode the pin is pulled low while the event is active and is released otherwise. The polarity bit is ignored in that mode.

A three-state machine sets the pin timing. `ST_IDLE` means the pin is inactive. `ST_PULSE` means a countdown of `PULSE_CYC` cycles is running; the default is 50 ms at 125 MHz. `ST_HOLD` means a level is held. The transitions are:
- IDLE→PULSE: an event arrives while enabled in pulse mode.
- IDLE→HOLD: an event arrives while enabled in continuous mode.
- PULSE→PULSE: a new event reloads the countdown.
- PULSE→HOLD: a new event arrives after the mode was switched to continuous.
- PULSE→IDLE: the countdown expires, or the status or enable is cleared.
- HOLD→IDLE: the status or enable is cleared.

Top module: `pme_wake_ctrl`

## Requirements
- R1: After reset, every register bit reads 0 (disabled, active-low, pulse mode, open-drain, status clear), `pme_oe` is 0 and `pme_irq` is 0.
- R2: Register layout: bit 0 is enable, bit 1 is polarity (1 = active high), bit 2 is indication mode (1 = continuous), bit 3 is buffer type (1 = push-pull) and bit 4 is wake status. When bit 3 is 1, `pme_oe` is always 1 and `pme_out` equals the active state XOR'd with the inverse of bit 1.
- R3: When bit 3 is 0 (open-drain), `pme_out` is always 0 and `pme_oe` is 1 exactly while the event is active, whatever the value of bit 1.
- R4: In pulse mode, an event sampled at a clock edge while enabled makes the pin active for exactly `PULSE_CYC` cycles, starting right after that edge.
- R5: An event during an active pulse reloads the countdown, so the pin stays active for `PULSE_CYC` cycles after the newest event.
- R6: In continuous mode, an event while enabled makes the pin active until the status bit or the enable bit is cleared.
- R7: An event sets the wake status bit even while the block is disabled. `pme_irq` always equals the status bit. Writing 1 to bit 4 clears the status, and writing 0 to bit 4 leaves it unchanged.
- R8: While the enable is 0 the pin is inactive. Clearing the enable or the status during an active pulse or level makes the pin inactive right after that write's edge.
- R9: When an event and a write of 1 to bit 4 fall in the same cycle, the status bit ends up set.
- R10: Setting the enable while the status is already set does not activate the pin. Only a new event does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Register write value (bit 4 is write-one-to-clear) |
| wake_evt | input | 1 | One-cycle wake detection from the MAC |
| rd_data | output | 5 | Register contents |
| pme_out | output | 1 | Pin drive value |
| pme_oe | output | 1 | Pin output-enable |
| pme_irq | output | 1 | Interrupt-status flag (wake status, not gated by the enable) |

## Verification
A wake detection and a software write of 1 to the status bit can fall in the same clock cycle. The bench provokes this by raising `wake_evt` in the same cycle as a clearing write. It expects the status to read back as 1 and `pme_irq` to stay high. A second overlap is a new event arriving while the pulse countdown is running. That case is judged by counting the active cycles, which must equal `PULSE_CYC` measured from the newer event.

// File: rtl/pme_pkg.sv
package pme_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } pme_state_t;

    // Control fields, MSB first: bit3 buffer type .. bit0 enable
    typedef struct packed {
        logic push_pull;
        logic cont_mode;
        logic act_high;
        logic enable;
    } pme_ctl_t;

    localparam int CTL_W = 4;
    localparam int STS_BIT = 4;
endpackage

// File: rtl/pme_csr.sv
module pme_csr
    import pme_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [4:0]     wr_data,
    input  logic           wake_evt,
    output pme_ctl_t       ctl_q,
    output pme_ctl_t       ctl_d,
    output logic           sts_q,
    output logic           sts_d
);
    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d = pme_ctl_t'(wr_data[CTL_W-1:0]);
        end
        // detection wins over a simultaneous clear
        sts_d = wake_evt | (sts_q & ~(wr_en & wr_data[STS_BIT]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            sts_q <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
            sts_q <= sts_d;
        end
    end
endmodule

// File: rtl/pme_fsm.sv
module pme_fsm
    import pme_pkg::*;
#(
    parameter int PULSE_CYC = 6_250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_evt,
    input  logic en_d,
    input  logic cont_d,
    input  logic sts_d,
    output logic active
);
    localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC - 1);

    pme_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic start;

    assign start = wake_evt & en_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = cont_d ? ST_HOLD : ST_PULSE;
                    cnt_d   = LOAD;
                end
            end
            ST_PULSE: begin
                if (!en_d || !sts_d) begin
                    state_d = ST_IDLE;
                end else if (wake_evt) begin
                    state_d = cont_d ? ST_HOLD : ST_PULSE;
                    cnt_d   = LOAD;
                end else if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HOLD: begin
                if (!en_d || !sts_d) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign active = (state_q != ST_IDLE);
endmodule

// File: rtl/pme_pin.sv
module pme_pin
    import pme_pkg::*;
(
    input  logic     active,
    input  pme_ctl_t ctl,
    output logic     pin_out,
    output logic     pin_oe
);
    always_comb begin
        if (ctl.push_pull) begin
            pin_oe  = 1'b1;
            pin_out = ctl.act_high ? active : ~active;
        end else begin
            pin_oe  = active;
            pin_out = 1'b0;
        end
    end
endmodule

// File: rtl/pme_wake_ctrl.sv
module pme_wake_ctrl
    import pme_pkg::*;
#(
    parameter int PULSE_CYC = 6_250_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [4:0] wr_data,
    input  logic       wake_evt,
    output logic [4:0] rd_data,
    output logic       pme_out,
    output logic       pme_oe,
    output logic       pme_irq
);
    pme_ctl_t ctl_q, ctl_d;
    logic sts_q, sts_d, active;

    pme_csr u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wake_evt(wake_evt), .ctl_q(ctl_q), .ctl_d(ctl_d),
        .sts_q(sts_q), .sts_d(sts_d)
    );

    pme_fsm #(.PULSE_CYC(PULSE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt),
        .en_d(ctl_d.enable), .cont_d(ctl_d.cont_mode), .sts_d(sts_d),
        .active(active)
    );

    pme_pin u_pin (
        .active(active), .ctl(ctl_q), .pin_out(pme_out), .pin_oe(pme_oe)
    );

    assign rd_data = {sts_q, ctl_q};
    assign pme_irq = sts_q;
endmodule

// File: rtl/pme_wake_ctrl_chk.sv
module pme_wake_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_clr,
    input logic       wake_evt,
    input logic [4:0] rd_data,
    input logic       pme_out,
    input logic       pme_oe,
    input logic       pme_irq
);
    logic pin_on;
    assign pin_on = rd_data[3] ? (pme_out == rd_data[1]) : pme_oe;

    a_r2_pp_drives: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] |-> pme_oe);
    a_r3_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[3] |-> !pme_out);
    a_r6_hold_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_evt && !wr_en && rd_data[0] && rd_data[2]) |=> pin_on);
    a_r7_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> rd_data[4]);
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_clr && !wake_evt) |=> !rd_data[4]);
    a_r7_irq_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        pme_irq == rd_data[4]);
    a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[0] |-> !pin_on);
    a_r9_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_evt && wr_en && wr_clr) |=> rd_data[4]);
endmodule

bind pme_wake_ctrl pme_wake_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_clr(wr_data[4]),
    .wake_evt(wake_evt), .rd_data(rd_data), .pme_out(pme_out),
    .pme_oe(pme_oe), .pme_irq(pme_irq)
);

// File: tb/pme_wake_ctrl_tb_top.sv
module pme_wake_ctrl_tb_top;
    localparam int P = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic wake_evt = 1'b0;
    logic [4:0] rd_data;
    logic pme_out, pme_oe, pme_irq;

    int n_chk = 0;
    int n_fail = 0;
    logic cfg_bt = 1'b0;
    logic cfg_pol = 1'b0;

    always #4 clk = ~clk;

    pme_wake_ctrl #(.PULSE_CYC(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wake_evt(wake_evt), .rd_data(rd_data), .pme_out(pme_out),
        .pme_oe(pme_oe), .pme_irq(pme_irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_pin(input string tag, input logic on);
        logic [1:0] exp;
        exp = cfg_bt ? {1'b1, (cfg_pol ? on : ~on)} : {on, 1'b0};
        chk(tag, {6'd0, pme_oe, pme_out}, {6'd0, exp});
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] d);
        wr_en = 1'b1; wr_data = d;
        cfg_bt = d[3]; cfg_pol = d[1];
        step();
        wr_en = 1'b0;
    endtask

    task automatic evt();
        wake_evt = 1'b1;
        step();
        wake_evt = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1;
        repeat (2) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 regs", {3'd0, rd_data}, 8'h00);
        chk("R1 oe/irq", {6'd0, pme_oe, pme_irq}, 8'h00);

        // R2 R3 R4 R7 sweep buffer type x polarity in pulse mode
        for (int bt = 0; bt < 2; bt++) begin
            for (int pol = 0; pol < 2; pol++) begin
                logic [4:0] c;
                c = {1'b0, bt[0], 1'b0, pol[0], 1'b1};
                wr(c);
                chk_pin("R2/R3 idle pin", 1'b0);
                evt();
                chk_pin("R4 pulse start", 1'b1);
                for (int i = 1; i < P; i++) begin
                    step();
                    chk_pin("R4 pulse body", 1'b1);
                end
                step();
                chk_pin("R4 pulse end", 1'b0);
                chk("R7 irq set", {7'd0, pme_irq}, 8'd1);
                wr({1'b0, c[3:0]});
                chk("R7 write 0 keeps status", {7'd0, rd_data[4]}, 8'd1);
                wr({1'b1, c[3:0]});
                chk("R7 w1c", {6'd0, rd_data[4], pme_irq}, 8'd0);
            end
        end

        // R5 retrigger (push-pull, active high)
        wr(5'b01011);
        evt();
        step(); step();
        evt();
        for (int i = 0; i < P; i++) begin
            chk_pin("R5 retrigger active", 1'b1);
            step();
        end
        chk_pin("R5 retrigger end", 1'b0);
        wr(5'b11011);

        // R6 continuous mode, cleared by status
        wr(5'b01111);
        evt();
        for (int i = 0; i < 2 * P; i++) begin
            chk_pin("R6 hold", 1'b1);
            step();
        end
        wr(5'b11111);
        chk_pin("R6 released by w1c", 1'b0);
        // R6 R8 cleared by enable
        evt();
        chk_pin("R6 hold again", 1'b1);
        wr(5'b01110);
        chk_pin("R8 released by enable", 1'b0);
        chk("R8 status kept", {7'd0, rd_data[4]}, 8'd1);
        // R10 re-enable with status set
        wr(5'b01111);
        step();
        chk_pin("R10 no retro assert", 1'b0);
        wr(5'b11111);

        // R7 R8 event while disabled, open-drain
        wr(5'b00000);
        evt();
        chk("R7 disabled sets irq", {7'd0, pme_irq}, 8'd1);
        chk_pin("R8 disabled pin", 1'b0);
        wr(5'b10000);

        // R8 pulse cut by w1c
        wr(5'b01011);
        evt();
        step();
        chk_pin("R8 pulse active", 1'b1);
        wr(5'b11011);
        chk_pin("R8 pulse cut", 1'b0);

        // R9 collision of event and clear
        evt();
        wake_evt = 1'b1; wr_en = 1'b1; wr_data = 5'b11011;
        step();
        wake_evt = 1'b0; wr_en = 1'b0;
        chk("R9 status kept", {6'd0, rd_data[4], pme_irq}, 8'd3);
        chk_pin("R9 pin still active", 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule